// File: doc/BRIEF.md
# Streaming AES-128 Encryption Pipeline

This block encrypts one 128-bit block per clock cycle under the AES-128 cipher. Every block arrives with its own 128-bit key and a valid flag. The whole ten-round cipher is unrolled into a chain of registers, so a new block can enter on every cycle and no stall is ever needed. The ciphertext leaves a fixed 41 cycles later with a matching valid flag. The key schedule is not precomputed. Each block's round keys are derived inside the pipeline as the block moves through it, so consecutive blocks can use unrelated keys.

The first register stage holds the plaintext combined with the raw key. Each of the ten rounds then takes four register stages: byte substitution, row rotation with column mixing, round-key derivation, and key addition. The last round skips column mixing but keeps all four stages, so every block sees the same latency. The substitution box is computed from field arithmetic, with no stored table. Only the valid chain is reset; the data registers are not.

Top module: `aes128_stream_enc`

## Requirements
- R1: The block with key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff encrypts to 69c4e0d86a7b0430d8cdb78070b4c55a. Byte 0 of every block and every key is bits [127:120], and the bytes go in descending order down to bits [7:0].
- R2: Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R3: Each block is encrypted with the key sampled in the same cycle as that block. Back-to-back blocks with different keys each give their own correct ciphertext.
- R4: `out_valid` is high in cycle t+41 exactly when `in_valid` was high in cycle t. Blocks may be presented on consecutive cycles, and gaps in the input stream appear unchanged at the output.
- R5: A synchronous active-high `rst` clears every valid bit. In the cycle after a reset edge, and until new blocks have gone through 41 stages, `out_valid` is low, and blocks that were in flight never emerge.
- R6: Byte substitution is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (zero maps to zero), followed by the affine transform with constant 0x63. An all-zero key and plaintext encrypt to 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R7: Rounds 1 to 9 apply column mixing after the row rotation. Round 10 applies only the row rotation.
- R8: Round keys use the round constants 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 for rounds 1 through 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | A block is presented this cycle |
| in_block | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| in_key | input | 128 | Key for this block, byte 0 in bits [127:120] |
| out_valid | output | 1 | Ciphertext on `out_block` is valid |
| out_block | output | 128 | Ciphertext block, byte 0 in bits [127:120] |

## Verification
Three known-answer blocks pin down the byte order (R1), the round-constant sequence (R2, R8) and the zero-input corner of the inverse (R6). A design that reversed the byte order, used the wrong constants or inverted zero wrongly would give a different ciphertext for these blocks. Long back-to-back runs with a fresh random key on every cycle are checked against an independent model in the bench; a design that mixed the key of one block into a neighbour, or that mixed columns in the last round, would miscompare (R3, R7). A random bubble pattern, and a reset asserted while blocks are in flight, show whether the valid chain loses, duplicates or resurrects a block, or whether it emerges off by a cycle (R4, R5).

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

    localparam int BLK_W       = 128;
    localparam int NBYTE       = BLK_W / 8;
    localparam int NCOL        = NBYTE / 4;
    localparam int NROUND      = 10;
    localparam int STG_PER_RND = 4;
    localparam int LATENCY     = 1 + NROUND * STG_PER_RND;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic vld;
        blk_t st;
        blk_t key;
    } lane_t;

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xt(x);
        end
        return acc;
    endfunction

    // a^254 is the inverse of a; it maps zero to zero.
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] sq  = a;
        logic [7:0] acc = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gmul(sq, sq);
            acc = gmul(acc, sq);
        end
        return acc;
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] v;
        v = ginv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] get_byte(input blk_t s, input int i);
        return s[BLK_W-1-8*i -: 8];
    endfunction

    function automatic blk_t sub_bytes(input blk_t s);
        blk_t o;
        for (int i = 0; i < NBYTE; i++) o[BLK_W-1-8*i -: 8] = sbox(get_byte(s, i));
        return o;
    endfunction

    function automatic logic [31:0] sub_word(input logic [31:0] w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    // Row r of column c takes the byte of column c+r.
    function automatic blk_t shift_rows(input blk_t s);
        blk_t o;
        for (int c = 0; c < NCOL; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-8*(4*c+r) -: 8] = get_byte(s, 4*((c+r)%NCOL)+r);
        return o;
    endfunction

    function automatic blk_t mix_cols(input blk_t s);
        blk_t o;
        logic [7:0] a0, a1, a2, a3;
        for (int c = 0; c < NCOL; c++) begin
            a0 = get_byte(s, 4*c);
            a1 = get_byte(s, 4*c+1);
            a2 = get_byte(s, 4*c+2);
            a3 = get_byte(s, 4*c+3);
            o[BLK_W-1-8*(4*c)   -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
            o[BLK_W-1-8*(4*c+1) -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
            o[BLK_W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
            o[BLK_W-1-8*(4*c+3) -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
        return o;
    endfunction

    function automatic logic [7:0] rcon_of(input int r);
        logic [7:0] v = 8'h01;
        for (int i = 1; i < r; i++) v = xt(v);
        return v;
    endfunction

    // Checker helper: XOR of all bytes of a block.
    function automatic logic [7:0] xor_fold(input blk_t s);
        logic [7:0] acc = 8'h00;
        for (int i = 0; i < NBYTE; i++) acc = acc ^ get_byte(s, i);
        return acc;
    endfunction

    // Checker helper: substitution never keeps a byte or its complement.
    function automatic logic all_moved(input blk_t after_s, input blk_t before_s);
        logic ok = 1'b1;
        for (int i = 0; i < NBYTE; i++)
            if (get_byte(after_s, i) == get_byte(before_s, i) ||
                get_byte(after_s, i) == ~get_byte(before_s, i)) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_core_pkg::*;
#(
    parameter logic [7:0] RCON = 8'h01
) (
    input  blk_t key_in,
    output blk_t key_out
);
    logic [31:0] w3_rot, tmix, n0_d, n1_d, n2_d, n3_d;

    always_comb begin
        w3_rot  = {key_in[23:0], key_in[31:24]};
        tmix    = sub_word(w3_rot) ^ {RCON, 24'h000000};
        n0_d    = key_in[127:96] ^ tmix;
        n1_d    = key_in[95:64]  ^ n0_d;
        n2_d    = key_in[63:32]  ^ n1_d;
        n3_d    = key_in[31:0]   ^ n2_d;
        key_out = {n0_d, n1_d, n2_d, n3_d};
    end
endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_core_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t in_l,
    output lane_t out_l
);
    localparam logic       LAST_RND = (ROUND == NROUND);
    localparam logic [7:0] RC       = rcon_of(ROUND);

    lane_t stg_d [STG_PER_RND];
    lane_t stg_q [STG_PER_RND];
    blk_t  rkey_d;

    aes_key_step #(.RCON(RC)) u_kstep (
        .key_in (stg_q[1].key),
        .key_out(rkey_d)
    );

    always_comb begin
        // stage 0: substitution
        stg_d[0].vld = in_l.vld;
        stg_d[0].st  = sub_bytes(in_l.st);
        stg_d[0].key = in_l.key;
        // stage 1: row rotation, column mixing except in the last round
        stg_d[1].vld = stg_q[0].vld;
        stg_d[1].st  = LAST_RND ? shift_rows(stg_q[0].st)
                                : mix_cols(shift_rows(stg_q[0].st));
        stg_d[1].key = stg_q[0].key;
        // stage 2: derive this round's key
        stg_d[2].vld = stg_q[1].vld;
        stg_d[2].st  = stg_q[1].st;
        stg_d[2].key = rkey_d;
        // stage 3: add round key
        stg_d[3].vld = stg_q[2].vld;
        stg_d[3].st  = stg_q[2].st ^ stg_q[2].key;
        stg_d[3].key = stg_q[2].key;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STG_PER_RND; i++) begin
            stg_q[i].st  <= stg_d[i].st;
            stg_q[i].key <= stg_d[i].key;
            stg_q[i].vld <= rst ? 1'b0 : stg_d[i].vld;
        end
    end

    assign out_l = stg_q[STG_PER_RND-1];

    // R6: the substitution box has no fixed and no complement-fixed points
    assert_sbox_nofix_R6: assert property (@(posedge clk) disable iff (rst)
        stg_q[0].vld |-> all_moved(stg_q[0].st, $past(in_l.st)));

    // R7: row rotation and column mixing both keep the XOR of all bytes
    assert_mix_parity_R7: assert property (@(posedge clk) disable iff (rst)
        stg_q[1].vld |-> xor_fold(stg_q[1].st) == $past(xor_fold(stg_q[0].st)));

    // R8: in a derived key, word3 ^ word2 equals the previous word3
    assert_key_chain_R8: assert property (@(posedge clk) disable iff (rst)
        stg_q[2].vld |-> (stg_q[2].key[31:0] ^ stg_q[2].key[63:32])
                         == $past(stg_q[1].key[31:0]));

    // R3: stripping the stored key restores the state seen one stage earlier
    assert_ark_R3: assert property (@(posedge clk) disable iff (rst)
        stg_q[3].vld |-> (stg_q[3].st ^ stg_q[3].key) == $past(stg_q[2].st));
endmodule

// File: rtl/aes128_stream_enc.sv
module aes128_stream_enc
    import aes_core_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] in_block,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_block
);
    localparam int CW = $clog2(LATENCY + 1);

    lane_t head_d, head_q;
    lane_t lanes [NROUND+1];

    always_comb begin
        head_d.vld = in_valid;
        head_d.st  = in_block ^ in_key;
        head_d.key = in_key;
    end

    always_ff @(posedge clk) begin
        head_q.st  <= head_d.st;
        head_q.key <= head_d.key;
        head_q.vld <= rst ? 1'b0 : head_d.vld;
    end

    assign lanes[0] = head_q;

    for (genvar r = 1; r <= NROUND; r++) begin : g_rnd
        aes_round #(.ROUND(r)) u_rnd (
            .clk  (clk),
            .rst  (rst),
            .in_l (lanes[r-1]),
            .out_l(lanes[r])
        );
    end

    assign out_valid = lanes[NROUND].vld;
    assign out_block = lanes[NROUND].st;

    // Cycles since reset, saturating; used only by the checks below.
    logic [CW-1:0] age_d, age_q;
    always_comb age_d = (age_q == CW'(LATENCY)) ? age_q : age_q + 1'b1;
    always_ff @(posedge clk) age_q <= rst ? '0 : age_d;

    assert_valid_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == CW'(LATENCY)) |-> out_valid == $past(in_valid, LATENCY));

    assert_valid_origin_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LATENCY));

    assert_valid_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/aes128_stream_enc_test.sv
module aes128_stream_enc_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_block = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_block;

    always #10 clk = ~clk;

    aes128_stream_enc uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
        .in_key(in_key), .out_valid(out_valid), .out_block(out_block)
    );

    int n_chk = 0;
    int n_bad = 0;
    int tick  = 0;
    logic [7:0]   sbt [256];
    logic         exp_v [64];
    logic [127:0] exp_d [64];
    string        exp_t [64];

    function automatic logic [7:0] bx(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] rl(input logic [7:0] a, input int k);
        return (a << k) | (a >> (8 - k));
    endfunction

    // Substitution table built by walking generator 3 and its inverse.
    task automatic build_sbox();
        logic [7:0] p = 8'h01, q = 8'h01, x;
        do begin
            p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sbt[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sbt[0] = 8'h63;
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] k);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] kb [16];
        logic [7:0] rc = 8'h01;
        logic [7:0] a0, a1, a2, a3, g0;
        logic [127:0] o;
        for (int i = 0; i < 16; i++) begin
            kb[i] = k[127-8*i -: 8];
            s[i]  = pt[127-8*i -: 8] ^ kb[i];
        end
        for (int r = 1; r <= 10; r++) begin
            g0 = kb[12];
            kb[0] = kb[0] ^ sbt[kb[13]] ^ rc;
            kb[1] = kb[1] ^ sbt[kb[14]];
            kb[2] = kb[2] ^ sbt[kb[15]];
            kb[3] = kb[3] ^ sbt[g0];
            for (int i = 4; i < 16; i++) kb[i] = kb[i] ^ kb[i-4];
            rc = bx(rc);
            for (int i = 0; i < 16; i++) s[i] = sbt[s[i]];
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++) t[4*c+w] = s[4*((c+w)%4)+w];
            for (int c = 0; c < 4; c++) begin
                a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                if (r < 10) begin
                    s[4*c]   = bx(a0) ^ (bx(a1) ^ a1) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ bx(a1) ^ (bx(a2) ^ a2) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ bx(a2) ^ (bx(a3) ^ a3);
                    s[4*c+3] = (bx(a0) ^ a0) ^ a1 ^ a2 ^ bx(a3);
                end else begin
                    s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ kb[i];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // One cycle: check what leaves now, record what enters, drive inputs.
    task automatic step(input logic r, input logic v, input logic [127:0] pt,
                        input logic [127:0] k, input logic [127:0] want, input string tag);
        int rs, ws;
        @(negedge clk);
        rs = (tick + 64 - 41) % 64;
        n_chk++;
        if (out_valid !== exp_v[rs]) begin
            n_bad++;
            $display("FAIL %s out_valid at tick %0d: got %b expected %b", exp_t[rs], tick, out_valid, exp_v[rs]);
        end
        if (exp_v[rs]) begin
            n_chk++;
            if (out_block !== exp_d[rs]) begin
                n_bad++;
                $display("FAIL %s out_block at tick %0d: got %h expected %h", exp_t[rs], tick, out_block, exp_d[rs]);
            end
        end
        if (r) begin
            for (int i = 0; i < 64; i++) begin
                exp_v[i] = 1'b0;
                exp_t[i] = "R5";
            end
        end
        ws = tick % 64;
        exp_v[ws] = v && !r;
        exp_d[ws] = want;
        exp_t[ws] = r ? "R5" : (v ? tag : "R4");
        rst      = r;
        in_valid = v;
        in_block = pt;
        in_key   = k;
        tick++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, "R4");
    endtask

    task automatic rand_block(input logic v, input string tag);
        logic [127:0] pt, k;
        pt = rnd128();
        k  = rnd128();
        step(1'b0, v, pt, k, ref_enc(pt, k), tag);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired at tick %0d", tick);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = '0;
            exp_t[i] = "R5";
        end
        build_sbox();

        // reset state: out_valid must read low (R5)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, '0, '0, "R5");

        // known answers, back to back
        step(1'b0, 1'b1, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
             128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1");
        step(1'b0, 1'b1, 128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
             128'h3925841d02dc09fbdc118597196a0b32, "R2 R8");
        step(1'b0, 1'b1, '0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R6");
        idle(45);

        // stream with a new key every cycle: R3, R7, R8
        for (int i = 0; i < 150; i++) rand_block(1'b1, "R3 R7");
        idle(10);

        // random gaps in the stream: R4
        for (int i = 0; i < 120; i++) rand_block(1'($urandom % 2), "R4");
        idle(45);

        // reset while blocks are in flight: none may emerge (R5)
        for (int i = 0; i < 25; i++) rand_block(1'b1, "R3");
        step(1'b1, 1'b1, rnd128(), rnd128(), '0, "R5");
        step(1'b1, 1'b0, '0, '0, '0, "R5");
        idle(50);

        // recovery after reset
        for (int i = 0; i < 8; i++) rand_block(1'b1, "R3");
        idle(45);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule